// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits in front of one channel of a DMA controller and decides when the channel may begin a transfer. It watches an active-low external request pin and synchronizes it. The pin is sensed either by level or by falling edge. The block issues a one-cycle start pulse to the transfer engine and then waits for the engine's done pulse. After the done pulse it opens again for new requests, either at once or after a one-cycle hold-off. While it waits it may also be disabled.

The block drives two active-low strobes. The acknowledge strobe marks the start cycle and is used only in single-address mode. The end strobe marks the engine's last transfer. Each strobe has its own active-low enable bit. An active status bit shows whether a transfer is in flight. All pins are plain control and status signals. There is no data stream and no handshake at the block's edge.

Top module: `dma_req_front`

## Requirements
- R1: With `edge_sel_i`=0, a synchronized low level on `req_n_i` starts a transfer. The start pulse appears two clock edges after the pin is sampled low, provided the channel is waiting.
- R2: With `edge_sel_i`=1 and `block_mode_i`=0, only a falling edge of the synchronized request (previous sample 1, current sample 0) starts a transfer. The exception is the first transfer after enabling (R3). A request held low does not start further transfers.
- R3: In edge mode, the first transfer after `chan_en_i` goes high, and the first after reset, is started by a low level.
- R4: With `block_mode_i`=1, requests are level-sensed whatever `edge_sel_i` holds.
- R5: With `hold_sel_i`=0, a request can start the next transfer in the cycle right after the cycle carrying `xfer_done_i`.
- R6: With `hold_sel_i`=1, no start pulse occurs in the cycle right after `xfer_done_i`. Requests are accepted one cycle later.
- R7: Only one transfer is outstanding. After a start pulse, no further start occurs until `xfer_done_i` has been seen.
- R8: `active_o` is 1 from the cycle after a start pulse until the channel again waits for a request. It is 0 while the channel waits or is disabled.
- R9: `ack_n_o` goes low exactly in a start cycle when `single_addr_i`=1 and `ack_dis_i`=0. Otherwise it stays high, and in dual-address mode (`single_addr_i`=0) `ack_dis_i` has no effect.
- R10: `end_n_o` goes low in a cycle where `xfer_last_i`=1 while a transfer is outstanding, provided `end_dis_i`=0. With `end_dis_i`=1 it stays high.
- R11: Dropping `chan_en_i` blocks start pulses in the same cycle. From the next cycle the channel is idle (`active_o`=0), any outstanding transfer is abandoned, and the level-sensed first-transfer rule is rearmed.
- R12: After reset the outputs read `start_o`=0, `ack_n_o`=1, `end_n_o`=1 and `active_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | External transfer request, active low, asynchronous |
| chan_en_i | input | 1 | Channel enable |
| edge_sel_i | input | 1 | 0 level sensing, 1 falling-edge sensing |
| hold_sel_i | input | 1 | 1 adds one idle cycle after done before new requests |
| ack_dis_i | input | 1 | 1 suppresses the acknowledge strobe |
| end_dis_i | input | 1 | 1 suppresses the end strobe |
| single_addr_i | input | 1 | 1 single-address mode, 0 dual-address mode |
| block_mode_i | input | 1 | 1 block transfer mode, forces level sensing |
| xfer_done_i | input | 1 | Engine pulse: current transfer finished |
| xfer_last_i | input | 1 | Engine pulse: current transfer is the last one |
| start_o | output | 1 | One-cycle transfer start |
| ack_n_o | output | 1 | Acknowledge strobe, active low |
| end_n_o | output | 1 | Transfer-end strobe, active low |
| active_o | output | 1 | Channel has a transfer in flight |

## Verification
A wrong internal state shows at the ports within one or two cycles. If the sequencer is stuck busy, `active_o` stays high and start pulses stop. If the first-transfer flag is stale, a held-low request in edge mode either starts an extra transfer or never starts the first one. If the synchronizer delay is off, every start pulse moves by a cycle. The bench compares every output on every clock against a behavioural model. A single misplaced or missing pulse is therefore caught in the cycle it happens.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_WAIT = 2'd1,
    CH_BUSY = 2'd2,
    CH_GAP  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic cur_n_o,
  output logic prev_n_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= pin_n_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else prev_q <= chain[STAGES-1];
  end

  assign cur_n_o  = chain[STAGES-1];
  assign prev_n_o = prev_q;
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect (
  input  logic cur_n_i,
  input  logic prev_n_i,
  input  logic edge_sel_i,
  input  logic block_mode_i,
  input  logic first_armed_i,
  output logic hit_o
);
  logic level_mode;

  // Block mode and the first transfer after enable are always level-sensed.
  assign level_mode = !edge_sel_i || block_mode_i || first_armed_i;
  assign hit_o      = !cur_n_i && (level_mode || prev_n_i);
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en_i,
  input  logic hold_sel_i,
  input  logic hit_i,
  input  logic xfer_done_i,
  output logic first_armed_o,
  output logic start_o,
  output logic busy_o,
  output logic active_o
);
  ch_state_e state_q, state_d;
  logic      first_q;

  assign start_o = chan_en_i && (state_q == CH_WAIT) && hit_i;

  always_comb begin
    state_d = state_q;
    if (!chan_en_i) begin
      state_d = CH_OFF;
    end else begin
      unique case (state_q)
        CH_OFF:  state_d = CH_WAIT;
        CH_WAIT: if (hit_i) state_d = CH_BUSY;
        CH_BUSY: if (xfer_done_i) state_d = hold_sel_i ? CH_GAP : CH_WAIT;
        CH_GAP:  state_d = CH_WAIT;
        default: state_d = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (!chan_en_i) first_q <= 1'b1;
      else if (start_o) first_q <= 1'b0;
    end
  end

  assign first_armed_o = first_q;
  assign busy_o        = (state_q == CH_BUSY);
  assign active_o      = (state_q == CH_BUSY) || (state_q == CH_GAP);

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_active_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> active_o);
  assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && xfer_done_i && hold_sel_i && chan_en_i) |=> !start_o);
  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |=> (!active_o && first_armed_o));
endmodule

// File: rtl/dma_req_strobe.sv
module dma_req_strobe (
  input  logic start_i,
  input  logic busy_i,
  input  logic single_addr_i,
  input  logic ack_dis_i,
  input  logic end_dis_i,
  input  logic xfer_last_i,
  output logic ack_n_o,
  output logic end_n_o
);
  assign ack_n_o = !(start_i && single_addr_i && !ack_dis_i);
  assign end_n_o = !(busy_i && xfer_last_i && !end_dis_i);
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dma_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic chan_en_i,
  input  logic edge_sel_i,
  input  logic hold_sel_i,
  input  logic ack_dis_i,
  input  logic end_dis_i,
  input  logic single_addr_i,
  input  logic block_mode_i,
  input  logic xfer_done_i,
  input  logic xfer_last_i,
  output logic start_o,
  output logic ack_n_o,
  output logic end_n_o,
  output logic active_o
);
  logic cur_n, prev_n, hit, first_armed, busy;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n_i(req_n_i),
    .cur_n_o(cur_n), .prev_n_o(prev_n)
  );

  dma_req_detect u_detect (
    .cur_n_i(cur_n), .prev_n_i(prev_n), .edge_sel_i(edge_sel_i),
    .block_mode_i(block_mode_i), .first_armed_i(first_armed), .hit_o(hit)
  );

  dma_req_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en_i), .hold_sel_i(hold_sel_i),
    .hit_i(hit), .xfer_done_i(xfer_done_i), .first_armed_o(first_armed),
    .start_o(start_o), .busy_o(busy), .active_o(active_o)
  );

  dma_req_strobe u_strobe (
    .start_i(start_o), .busy_i(busy), .single_addr_i(single_addr_i),
    .ack_dis_i(ack_dis_i), .end_dis_i(end_dis_i), .xfer_last_i(xfer_last_i),
    .ack_n_o(ack_n_o), .end_n_o(end_n_o)
  );

  assert_ack_dual_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !single_addr_i |-> ack_n_o);
  assert_end_muted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_dis_i |-> end_n_o);
  assert_block_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (block_mode_i && chan_en_i && !active_o && !cur_n && $past(chan_en_i) && $past(!active_o)) |-> start_o);
endmodule

// File: tb/dma_req_front_bench.sv
module dma_req_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, en = 1'b0, edge_sel = 1'b0, hold_sel = 1'b0;
  logic ack_dis = 1'b0, end_dis = 1'b0, single = 1'b1, block = 1'b0;
  logic done = 1'b0, last = 1'b0;
  logic start_o, ack_n_o, end_n_o, active_o;

  always #2 clk = ~clk;

  dma_req_front u_dma_req_front (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .chan_en_i(en),
    .edge_sel_i(edge_sel), .hold_sel_i(hold_sel), .ack_dis_i(ack_dis),
    .end_dis_i(end_dis), .single_addr_i(single), .block_mode_i(block),
    .xfer_done_i(done), .xfer_last_i(last), .start_o(start_o),
    .ack_n_o(ack_n_o), .end_n_o(end_n_o), .active_o(active_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R12";

  // behavioural model
  bit samples[$];
  int mode = 0;      // 0 off, 1 waiting, 2 busy, 3 hold-off
  bit first = 1;
  bit m_start, m_ack, m_end, m_act;

  task automatic cmp(string nm, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, nm, act, exp, cycles);
    end
  endtask

  task automatic step();
    bit cur, prv, lvl;
    #1;
    cur = samples[1];
    prv = samples[2];
    lvl = !edge_sel || block || first;
    m_start = en && mode == 1 && !cur && (lvl || prv);
    m_ack   = !(m_start && single && !ack_dis);
    m_end   = !(mode == 2 && last && !end_dis);
    m_act   = (mode >= 2);
    cmp("start_o", start_o, m_start);
    cmp("ack_n_o", ack_n_o, m_ack);
    cmp("end_n_o", end_n_o, m_end);
    cmp("active_o", active_o, m_act);
    @(posedge clk);
    if (!en) begin
      mode = 0; first = 1;
    end else begin
      case (mode)
        0: mode = 1;
        1: if (m_start) begin mode = 2; first = 0; end
        2: if (done) mode = hold_sel ? 3 : 1;
        default: mode = 1;
      endcase
    end
    samples.push_front(req_n);
    void'(samples.pop_back());
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // wait for a start, hold busy for lat cycles, then signal done
  task automatic serve(int lat, bit is_last);
    for (int i = 0; i < 40; i++) begin
      step();
      if (m_start) break;
    end
    steps(lat);
    done = 1; last = is_last;
    step();
    done = 0; last = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    samples = '{1'b1, 1'b1, 1'b1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R12"; steps(3);

    tag = "R1"; en = 1; steps(2); req_n = 0; serve(2, 0);
    tag = "R5"; serve(1, 0); serve(0, 0);
    tag = "R7"; serve(4, 0);
    tag = "R6"; hold_sel = 1; serve(1, 0); serve(2, 0); steps(3); hold_sel = 0;

    tag = "R11"; en = 0; steps(2); req_n = 1; steps(3);
    tag = "R3"; edge_sel = 1; req_n = 0; en = 1; serve(1, 0);
    tag = "R2"; steps(6); req_n = 1; steps(3); req_n = 0; serve(1, 0); steps(4);
    tag = "R4"; block = 1; serve(1, 0); serve(1, 0); block = 0; steps(3);

    tag = "R9"; edge_sel = 0; ack_dis = 1; serve(1, 0);
    single = 0; ack_dis = 0; serve(1, 0); ack_dis = 1; serve(1, 0);
    single = 1; ack_dis = 0; serve(1, 0);
    tag = "R10"; serve(1, 1); end_dis = 1; serve(1, 1); end_dis = 0;
    last = 1; steps(2); last = 0;

    tag = "R11"; serve(0, 0); step(); steps(1); en = 0; steps(3);
    en = 1; edge_sel = 1; serve(1, 0); steps(3); edge_sel = 0;
    req_n = 1; steps(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule